// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block sits beside the byte-load controller of a sector-programmed non-volatile store and decides, at the end of each sector load, whether the loaded data may be committed to the array. It watches the stream of qualified byte-load events (address plus data). Consecutive events belong to one load until the gap between two of them exceeds a configurable window. When that window lapses, the block issues one registered verdict: commit the sector buffer, start the program busy period, or discard the load.

A persistent protection flag gates the verdict. It is off when the store leaves the factory. A load that opens with three fixed address/data command pairs turns it on. A load that opens with a longer six-pair sequence turns it off. While the flag is set, every load must open with the three-pair unlock prefix, or the load is thrown away and no busy period starts.

The block's synchronous reset input does not touch the flag. Only a separate factory-clear input does. With each verdict the block reports how many leading loads were consumed as commands, so that the sector buffer can skip them.

Top module: `swp_guard`

## Requirements
- R1: `prot_on` is 0 after `factory_clr` and before any enable sequence. Asserting `rst` never changes `prot_on`, and `factory_clr` forces it to 0 even while protection is on.
- R2: With protection off, a load that does not open with a recognised sequence ends with `commit`=1, `busy_start`=1, `abort`=0 and `pfx_len`=0, and `prot_on` stays 0.
- R3: A load opening with address 0x5555 / data 0xAA, then 0x2AAA/0x55, then 0x5555/0xA0 sets `prot_on` to 1 in the verdict cycle. That verdict has `pfx_len`=3 and `busy_start`=1, and it has `commit`=1 when at least one further byte followed the prefix.
- R4: With protection on, a load that does not open with the three-pair prefix ends with `abort`=1, `commit`=0 and `busy_start`=0, and `prot_on` stays 1.
- R5: With protection on, a load opening with the three-pair prefix followed by data ends with `commit`=1, `busy_start`=1 and `pfx_len`=3.
- R6: A load that consists of the three-pair prefix alone gives `busy_start`=1 and `commit`=0. The busy period runs but nothing is written.
- R7: A load opening with 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20 clears `prot_on` to 0 in the verdict cycle. That verdict has `busy_start`=1 and `pfx_len`=6, with `commit`=1 only if data followed.
- R8: A wrong address or data value at any prefix position ends matching for the rest of that load, and the load is treated as having no prefix (`pfx_len`=0).
- R9: Two events at most `WINDOW_CYC` clock edges apart belong to one load. A gap of `WINDOW_CYC`+1 edges ends the load, and a partial prefix cut short by that gap does not count.
- R10: `commit`, `abort` and `busy_start` are single-cycle pulses. `commit` and `abort` are never high together, and `commit` implies `busy_start`.
- R11: `rst` discards any load in progress without a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; leaves the protection flag alone |
| factory_clr | input | 1 | Clears the protection flag to its as-delivered off state |
| ld_vld | input | 1 | One-cycle strobe for a qualified byte-load event |
| ld_addr | input | ADDR_W (16) | Address of the byte-load event |
| ld_data | input | DATA_W (8) | Data of the byte-load event |
| prot_on | output | 1 | Protection flag |
| commit | output | 1 | Pulse: write the loaded sector |
| abort | output | 1 | Pulse: discard the loaded sector |
| busy_start | output | 1 | Pulse: start the program busy period |
| pfx_len | output | 3 | Leading loads consumed as commands (0, 3 or 6), valid with a verdict pulse |

## Verification
The assertions assume that `factory_clr` never lands in the same cycle as a verdict. Without that, a verdict could report a completed enable prefix while the flag has just been forced off. They also assume that each `ld_vld` strobe is a single qualified event, so two verdicts are always at least a full window apart. The stimulus raises `factory_clr` only while no load is open, and always drives single-cycle strobes. It times the spacing of events in whole clock edges, landing on both sides of the window boundary.

// File: rtl/swp_pkg.sv
package swp_pkg;

  localparam int unsigned PFX_EN_LEN  = 3;
  localparam int unsigned PFX_DIS_LEN = 6;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_SEQ,
    MS_EN_OK,
    MS_DIS_OK,
    MS_DATA
  } match_e;

  typedef struct packed {
    logic       commit;
    logic       abort;
    logic       busy;
    logic [2:0] pfx;
  } verdict_t;

endpackage

// File: rtl/swp_win_timer.sv
module swp_win_timer #(
  parameter int unsigned WINDOW_CYC = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic ev,
  output logic expire
);
  localparam int unsigned CW = (WINDOW_CYC > 2) ? $clog2(WINDOW_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYC - 1);

  logic          active_q;
  logic [CW-1:0] gap_q;

  assign expire = active_q && !ev && (gap_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      gap_q    <= '0;
    end else if (ev) begin
      active_q <= 1'b1;
      gap_q    <= '0;
    end else if (expire) begin
      active_q <= 1'b0;
      gap_q    <= '0;
    end else if (active_q) begin
      gap_q    <= gap_q + CW'(1);
    end
  end
endmodule

// File: rtl/swp_seq_match.sv
module swp_seq_match
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_HI = 16'h5555,
  parameter logic [ADDR_W-1:0] A_LO = 16'h2AAA,
  parameter logic [DATA_W-1:0] K1   = 8'hAA,
  parameter logic [DATA_W-1:0] K2   = 8'h55,
  parameter logic [DATA_W-1:0] K_EN = 8'hA0,
  parameter logic [DATA_W-1:0] K_ER = 8'h80,
  parameter logic [DATA_W-1:0] K_DS = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              flush,
  output match_e            mode,
  output logic              data_seen
);
  localparam logic [ADDR_W-1:0] EXP_A [PFX_DIS_LEN] = '{A_HI, A_LO, A_HI, A_HI, A_LO, A_HI};
  localparam logic [DATA_W-1:0] EXP_D [PFX_DIS_LEN] = '{K1, K2, K_ER, K1, K2, K_DS};
  localparam logic [2:0] EN_POS  = 3'(PFX_EN_LEN - 1);
  localparam logic [2:0] DIS_POS = 3'(PFX_DIS_LEN - 1);

  logic [PFX_DIS_LEN-1:0] hit;
  logic                   en_hit;
  match_e                 mode_q;
  logic [2:0]             step_q;
  logic                   seen_q;

  for (genvar g = 0; g < PFX_DIS_LEN; g++) begin : g_cmp
    assign hit[g] = (addr == EXP_A[g]) && (data == EXP_D[g]);
  end

  assign en_hit    = (addr == A_HI) && (data == K_EN);
  assign mode      = mode_q;
  assign data_seen = seen_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      mode_q <= MS_IDLE;
      step_q <= '0;
      seen_q <= 1'b0;
    end else if (ev) begin
      case (mode_q)
        MS_IDLE, MS_SEQ: begin
          if (step_q == EN_POS && en_hit) begin
            mode_q <= MS_EN_OK;
          end else if (hit[step_q]) begin
            if (step_q == DIS_POS) begin
              mode_q <= MS_DIS_OK;
            end else begin
              mode_q <= MS_SEQ;
              step_q <= step_q + 3'd1;
            end
          end else begin
            mode_q <= MS_DATA;
          end
        end
        MS_EN_OK, MS_DIS_OK: seen_q <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swp_prot_flag.sv
module swp_prot_flag (
  input  logic clk,
  input  logic factory_clr,
  input  logic set_req,
  input  logic clr_req,
  output logic prot
);
  logic prot_q = 1'b0;

  assign prot = prot_q;

  always_ff @(posedge clk) begin
    if (factory_clr)  prot_q <= 1'b0;
    else if (set_req) prot_q <= 1'b1;
    else if (clr_req) prot_q <= 1'b0;
  end
endmodule

// File: rtl/swp_verdict.sv
module swp_verdict
  import swp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  match_e     mode,
  input  logic       data_seen,
  input  logic       prot,
  output logic       set_req,
  output logic       clr_req,
  output verdict_t   vq
);
  verdict_t vd;

  assign set_req = !rst && expire && (mode == MS_EN_OK);
  assign clr_req = !rst && expire && (mode == MS_DIS_OK);

  always_comb begin
    vd = '0;
    if (expire) begin
      case (mode)
        MS_EN_OK: begin
          vd.busy   = 1'b1;
          vd.commit = data_seen;
          vd.pfx    = 3'(PFX_EN_LEN);
        end
        MS_DIS_OK: begin
          vd.busy   = 1'b1;
          vd.commit = data_seen;
          vd.pfx    = 3'(PFX_DIS_LEN);
        end
        MS_SEQ, MS_DATA: begin
          if (prot) begin
            vd.abort  = 1'b1;
          end else begin
            vd.commit = 1'b1;
            vd.busy   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vq <= '0;
    else     vq <= vd;
  end
endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WINDOW_CYC = 150,
  parameter logic [ADDR_W-1:0] A_HI = 16'h5555,
  parameter logic [ADDR_W-1:0] A_LO = 16'h2AAA,
  parameter logic [DATA_W-1:0] K1   = 8'hAA,
  parameter logic [DATA_W-1:0] K2   = 8'h55,
  parameter logic [DATA_W-1:0] K_EN = 8'hA0,
  parameter logic [DATA_W-1:0] K_ER = 8'h80,
  parameter logic [DATA_W-1:0] K_DS = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              factory_clr,
  input  logic              ld_vld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              prot_on,
  output logic              commit,
  output logic              abort,
  output logic              busy_start,
  output logic [2:0]        pfx_len
);
  logic     expire;
  match_e   mode;
  logic     data_seen;
  logic     set_req;
  logic     clr_req;
  verdict_t vq;

  swp_win_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk(clk), .rst(rst), .ev(ld_vld), .expire(expire)
  );

  swp_seq_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_HI(A_HI), .A_LO(A_LO),
    .K1(K1), .K2(K2), .K_EN(K_EN), .K_ER(K_ER), .K_DS(K_DS)
  ) u_match (
    .clk(clk), .rst(rst), .ev(ld_vld), .addr(ld_addr), .data(ld_data),
    .flush(expire), .mode(mode), .data_seen(data_seen)
  );

  swp_prot_flag u_flag (
    .clk(clk), .factory_clr(factory_clr), .set_req(set_req),
    .clr_req(clr_req), .prot(prot_on)
  );

  swp_verdict u_verdict (
    .clk(clk), .rst(rst), .expire(expire), .mode(mode),
    .data_seen(data_seen), .prot(prot_on), .set_req(set_req),
    .clr_req(clr_req), .vq(vq)
  );

  assign commit     = vq.commit;
  assign abort      = vq.abort;
  assign busy_start = vq.busy;
  assign pfx_len    = vq.pfx;
endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       factory_clr,
  input logic       prot_on,
  input logic       commit,
  input logic       abort,
  input logic       busy_start,
  input logic [2:0] pfx_len
);
  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    commit |-> !abort);
  assert_commit_busy_R10: assert property (@(posedge clk) disable iff (rst)
    commit |-> busy_start);
  assert_busy_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    busy_start |=> !busy_start);
  assert_abort_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);
  assert_abort_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    abort |-> (!busy_start && prot_on));
  assert_flag_source_R1: assert property (@(posedge clk) disable iff (rst)
    (prot_on != $past(prot_on)) |-> (busy_start || $past(factory_clr)));
  assert_enable_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_start && pfx_len == 3'd3 && !$past(factory_clr)) |-> prot_on);
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_start && pfx_len == 3'd6) |-> !prot_on);
  assert_plain_off_R2: assert property (@(posedge clk) disable iff (rst)
    (commit && pfx_len == 3'd0) |-> !prot_on);
endmodule

bind swp_guard swp_guard_chk u_chk (
  .clk(clk), .rst(rst), .factory_clr(factory_clr), .prot_on(prot_on),
  .commit(commit), .abort(abort), .busy_start(busy_start), .pfx_len(pfx_len)
);

// File: tb/sim_swp_guard.sv
`timescale 1ns/1ps
module sim_swp_guard;
  localparam int WIN = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        factory_clr = 1'b1;
  logic        ld_vld = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        prot_on, commit, abort, busy_start;
  logic [2:0]  pfx_len;

  int n_chk = 0;
  int n_err = 0;
  int c_cnt = 0, a_cnt = 0, b_cnt = 0, last_pfx = 0;
  int sc, sa, sb;

  always #4 clk = ~clk;

  swp_guard #(.WINDOW_CYC(WIN)) u0 (
    .clk(clk), .rst(rst), .factory_clr(factory_clr), .ld_vld(ld_vld),
    .ld_addr(ld_addr), .ld_data(ld_data), .prot_on(prot_on), .commit(commit),
    .abort(abort), .busy_start(busy_start), .pfx_len(pfx_len)
  );

  always @(negedge clk) begin
    if (commit) c_cnt++;
    if (abort) a_cnt++;
    if (busy_start) b_cnt++;
    if (commit || abort || busy_start) last_pfx = int'(pfx_len);
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err + 1);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d, input int gap);
    @(negedge clk);
    ld_vld = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic snap();
    sc = c_cnt; sa = a_cnt; sb = b_cnt; last_pfx = -1;
  endtask

  task automatic settle();
    repeat (WIN + 6) @(negedge clk);
  endtask

  task automatic verdict(input string tag, input int c, input int a, input int b, input int p);
    chk({tag, " commit"}, c_cnt - sc, c);
    chk({tag, " abort"}, a_cnt - sa, a);
    chk({tag, " busy"}, b_cnt - sb, b);
    if (p >= 0) chk({tag, " pfx"}, last_pfx, p);
  endtask

  task automatic unlock();
    put(16'h5555, 8'hAA, 2);
    put(16'h2AAA, 8'h55, 2);
    put(16'h5555, 8'hA0, 2);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    factory_clr = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 prot after factory clear", int'(prot_on), 0);
    chk("R10 idle outputs", int'(commit | abort | busy_start), 0);
  endtask

  task automatic t_plain_off();
    snap();
    put(16'h0100, 8'h11, 2); put(16'h0101, 8'h22, 2); put(16'h0102, 8'h33, 2);
    settle();
    verdict("R2 plain load", 1, 0, 1, 0);
    chk("R2 prot stays off", int'(prot_on), 0);
  endtask

  task automatic t_enable();
    snap();
    unlock(); put(16'h0200, 8'h5A, 2); put(16'h0201, 8'hA5, 2);
    settle();
    verdict("R3 enable with data", 1, 0, 1, 3);
    chk("R3 prot set", int'(prot_on), 1);
  endtask

  task automatic t_reset_keeps();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 rst keeps prot", int'(prot_on), 1);
  endtask

  task automatic t_locked_plain();
    snap();
    put(16'h0300, 8'h01, 2); put(16'h0301, 8'h02, 2);
    settle();
    verdict("R4 locked no prefix", 0, 1, 0, 0);
    chk("R4 prot stays on", int'(prot_on), 1);
  endtask

  task automatic t_locked_unlock();
    snap();
    unlock(); put(16'h0400, 8'h77, 2);
    settle();
    verdict("R5 locked with prefix", 1, 0, 1, 3);
  endtask

  task automatic t_prefix_only();
    snap();
    unlock();
    settle();
    verdict("R6 prefix alone", 0, 0, 1, 3);
    chk("R6 prot still on", int'(prot_on), 1);
  endtask

  task automatic t_mismatch_locked();
    snap();
    put(16'h5555, 8'hAA, 2); put(16'h2AAA, 8'h55, 2); put(16'h5555, 8'hA1, 2);
    put(16'h0500, 8'h10, 2);
    settle();
    verdict("R8 mismatch while locked", 0, 1, 0, 0);
  endtask

  task automatic t_split_prefix();
    snap();
    put(16'h5555, 8'hAA, 2); put(16'h2AAA, 8'h55, WIN - 1);
    put(16'h5555, 8'hA0, 2); put(16'h0600, 8'h44, 2);
    settle();
    verdict("R9 prefix split by window", 0, 2, 0, 0);
  endtask

  task automatic t_disable();
    snap();
    put(16'h5555, 8'hAA, 2); put(16'h2AAA, 8'h55, 2); put(16'h5555, 8'h80, 2);
    put(16'h5555, 8'hAA, 2); put(16'h2AAA, 8'h55, 2); put(16'h5555, 8'h20, 2);
    settle();
    verdict("R7 disable", 0, 0, 1, 6);
    chk("R7 prot cleared", int'(prot_on), 0);
  endtask

  task automatic t_window_edges();
    snap();
    put(16'h0700, 8'h01, WIN - 2); put(16'h0701, 8'h02, 2);
    settle();
    verdict("R9 spacing at window", 1, 0, 1, 0);
    snap();
    put(16'h0700, 8'h01, WIN - 1); put(16'h0701, 8'h02, 2);
    settle();
    verdict("R9 spacing past window", 2, 0, 2, 0);
  endtask

  task automatic t_mismatch_open();
    snap();
    put(16'h5555, 8'hAA, 2); put(16'h2AAA, 8'h55, 2); put(16'h5555, 8'h33, 2);
    settle();
    verdict("R8 mismatch while open", 1, 0, 1, 0);
  endtask

  task automatic t_reset_midload();
    snap();
    put(16'h5555, 8'hAA, 2); put(16'h2AAA, 8'h55, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    settle();
    verdict("R11 reset drops load", 0, 0, 0, -1);
    chk("R11 prot untouched", int'(prot_on), 0);
  endtask

  task automatic t_factory_clear();
    snap();
    unlock();
    settle();
    chk("R3 enable alone sets prot", int'(prot_on), 1);
    @(negedge clk); factory_clr = 1'b1;
    @(negedge clk); factory_clr = 1'b0;
    @(negedge clk);
    chk("R1 factory clear", int'(prot_on), 0);
  endtask

  initial begin
    t_reset_state();
    t_plain_off();
    t_enable();
    t_reset_keeps();
    t_locked_plain();
    t_locked_unlock();
    t_prefix_only();
    t_mismatch_locked();
    t_split_prefix();
    t_disable();
    t_window_edges();
    t_mismatch_open();
    t_reset_midload();
    t_factory_clear();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule